// File: doc/BRIEF.md
# Handshaked Peripheral DMA Channel

This block is one DMA channel driven from a four-word register bank. Software loads a source address, a destination address and a count of transfer cycles, then writes a control word whose enable bit starts the channel. Each cycle reads a word from the source and writes it to the destination, one beat at a time. Each side sits either on the memory bus or on the peripheral bus, and each side has its own signed address step. Burst mode groups four beats into one cycle.

A side may be tied to one of fifteen request lines. Before each cycle the channel waits for every selected request. After the cycle's last write it pulses the matching grants. The remaining cycle count can be read while the channel runs. Completion and configuration errors show up as status bits in the control word, and each has its own interrupt enable.

Top module: `hs_dma_channel`

## Requirements
- R1: The bank decodes aligned byte offsets 0 (source address), 4 (destination address), 8 (cycle count, low 24 bits kept) and 12 (control). A write to an offset with nonzero low two bits is ignored. After reset every register reads zero.
- R2: Writing control with bit 0 set while idle starts the channel. The stored control fields read back as written. Bit 0 reads 1 while the channel is active and 0 once it stops.
- R3: Each beat reads the source address and then writes the word it read to the destination address. The source uses the memory bus when control bit 6 is 1, the destination when bit 7 is 1 (`mem_main_o` high), and otherwise the peripheral bus. `mem_size_o` carries control bits 21:20 (00 word, 01 half, 10 byte).
- R4: Source step code is in bits 10:8 and destination step code in bits 14:12. Code 000 holds the address. Codes 001/010/011 add 1/2/4 after every beat on that side. Codes 101/110/111 subtract 1/2/4.
- R5: With control bit 3 set, one cycle is four beats, so the address moves four times its step per cycle. With bit 3 clear, a cycle is one beat.
- R6: The count drops by one at the end of each cycle. Reading offset 8 during a transfer returns the cycles still to do.
- R7: When the last cycle ends, the channel stops and sets finish status (bit 1). `irq_done_o` is high while bit 1 and bit 2 are both set.
- R8: Bits 27:24 select the source request line and bits 19:16 the destination line. Value 0 means the side is not paced. Value n makes each cycle wait until `req_i[n-1]` is high, and `grant_o[n-1]` is then high for exactly one clock after the cycle's last write.
- R9: Starting with step code 100 on either side, or width code 11, makes no memory access. Instead it sets error status (bit 4). `irq_err_o` is high while bit 4 and bit 5 are both set.
- R10: Starting with a count of zero sets finish status at once and makes no memory access.
- R11: A control write with a status bit at 0 clears that bit. Writing 1 to a status bit has no effect.
- R12: A control write with bit 0 clear while active stops the channel at once. No further access follows and finish status is not set.
- R13: While the channel is active, writes to offsets 0, 4 and 8 are ignored, and control writes change no stored field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| mem_rd_o | output | 1 | Read beat on the master port |
| mem_wr_o | output | 1 | Write beat on the master port |
| mem_main_o | output | 1 | 1 selects the memory bus, 0 the peripheral bus |
| mem_size_o | output | 2 | Element width code |
| mem_addr_o | output | AW | Beat address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid in the read beat's cycle |
| req_i | input | NUM_LINES | Request lines 1..NUM_LINES (bit n-1 is line n) |
| grant_o | output | NUM_LINES | Grant pulses, same bit order |
| irq_done_o | output | 1 | Completion interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
The embedded properties check these behaviours on every cycle: a read beat never leaves the request wait unless the selected requests were present, a grant lasts a single clock, the live count never rises and drops by at most one per clock while active, a channel that stops has either reached zero or been stopped by software, and a side with step 000 never moves. Other behaviours can only be shown by the scenarios. These include the exact address and data order of each beat, with burst grouping and signed steps, the final addresses and count, and the status and interrupt behaviour. The scenarios also show that bad configurations, zero counts, stops and writes made while busy cause no memory traffic.

// File: rtl/hsdma_pkg.sv
package hsdma_pkg;
   // control word bit positions (software-visible layout)
   localparam int CTL_EN       = 0;
   localparam int CTL_FIN      = 1;
   localparam int CTL_FIE      = 2;
   localparam int CTL_BURST    = 3;
   localparam int CTL_ERR      = 4;
   localparam int CTL_EIE      = 5;
   localparam int CTL_SMAIN    = 6;
   localparam int CTL_DMAIN    = 7;
   localparam int CTL_SSTEP_LO = 8;
   localparam int CTL_DSTEP_LO = 12;
   localparam int CTL_DLINE_LO = 16;
   localparam int CTL_SIZE_LO  = 20;
   localparam int CTL_SLINE_LO = 24;
   localparam int LINE_W       = 4;
   localparam int STEP_W       = 3;

   typedef enum logic [2:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR, ST_END} eng_state_t;
   typedef enum logic [1:0] {SEL_SRC = 2'd0, SEL_DST = 2'd1, SEL_CNT = 2'd2, SEL_CTL = 2'd3} reg_sel_t;

   function automatic logic [2:0] step_bytes(input logic [STEP_W-1:0] code);
      case (code[1:0])
         2'd1:    return 3'd1;
         2'd2:    return 3'd2;
         2'd3:    return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

   function automatic logic step_reserved(input logic [STEP_W-1:0] code);
      return code == 3'b100;
   endfunction
endpackage

// File: rtl/hsdma_addr_step.sv
module hsdma_addr_step
   import hsdma_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ld_i,
   input  logic [AW-1:0]     ld_val_i,
   input  logic              adv_i,
   input  logic [STEP_W-1:0] code_i,
   output logic [AW-1:0]     addr_o
);
   logic [AW-1:0] addr_q;
   logic [AW-1:0] mag;

   always_comb mag = AW'(step_bytes(code_i));

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     addr_q <= '0;
      else if (ld_i)   addr_q <= ld_val_i;
      else if (adv_i)  addr_q <= code_i[STEP_W-1] ? addr_q - mag : addr_q + mag;
   end

   assign addr_o = addr_q;

   // R4: a side with step 000 never moves
   assert_fixed_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ld_i && code_i == 3'b000) |=> $stable(addr_q));
endmodule

// File: rtl/hsdma_pacer.sv
module hsdma_pacer
   import hsdma_pkg::*;
#(
   parameter int NUM_LINES = 15
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [LINE_W-1:0]    src_line_i,
   input  logic [LINE_W-1:0]    dst_line_i,
   input  logic [NUM_LINES-1:0] req_i,
   input  logic                 grant_pulse_i,
   output logic                 ready_o,
   output logic [NUM_LINES-1:0] grant_o
);
   logic [NUM_LINES-1:0] src_hit, dst_hit;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      assign src_hit[g] = (src_line_i == LINE_W'(g + 1));
      assign dst_hit[g] = (dst_line_i == LINE_W'(g + 1));
      assign grant_o[g] = grant_pulse_i & (src_hit[g] | dst_hit[g]);
   end

   assign ready_o = ((src_line_i == '0) | (|(req_i & src_hit)))
                  & ((dst_line_i == '0) | (|(req_i & dst_hit)));

   // R8: grants are single-clock pulses
   assert_grant_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o != '0) |=> (grant_o == '0));
endmodule

// File: rtl/hsdma_engine.sv
module hsdma_engine
   import hsdma_pkg::*;
#(
   parameter int CW          = 24,
   parameter int BURST_BEATS = 4
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic          cfg_bad_i,
   input  logic          abort_i,
   input  logic          burst_i,
   input  logic          ready_i,
   input  logic          cnt_wr_i,
   input  logic [CW-1:0] cnt_wdata_i,
   output logic          busy_o,
   output logic          rd_o,
   output logic          wr_o,
   output logic          grant_pulse_o,
   output logic          done_o,
   output logic          err_o,
   output logic [CW-1:0] cnt_o
);
   localparam int BW = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;

   eng_state_t    st_q, st_d;
   logic [BW-1:0] beat_q, beat_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          last_beat;

   assign last_beat = burst_i ? (beat_q == BW'(BURST_BEATS - 1)) : 1'b1;

   always_comb begin
      st_d   = st_q;
      beat_d = beat_q;
      cnt_d  = cnt_q;
      done_o = 1'b0;
      err_o  = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (cnt_wr_i) cnt_d = cnt_wdata_i;
            if (start_i) begin
               if (cfg_bad_i)          err_o  = 1'b1;
               else if (cnt_q == '0)   done_o = 1'b1;
               else begin
                  st_d   = ST_WAIT;
                  beat_d = '0;
               end
            end
         end
         ST_WAIT: if (ready_i) st_d = ST_RD;
         ST_RD:   st_d = ST_WR;
         ST_WR: begin
            if (last_beat) st_d = ST_END;
            else begin
               beat_d = beat_q + BW'(1);
               st_d   = ST_RD;
            end
         end
         ST_END: begin
            cnt_d  = cnt_q - CW'(1);
            beat_d = '0;
            if (cnt_q == CW'(1)) begin
               st_d   = ST_IDLE;
               done_o = 1'b1;
            end else begin
               st_d = ST_WAIT;
            end
         end
         default: st_d = ST_IDLE;
      endcase
      if (abort_i && st_q != ST_IDLE) begin
         st_d   = ST_IDLE;
         beat_d = '0;
         cnt_d  = cnt_q;
         done_o = 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         beat_q <= '0;
         cnt_q  <= '0;
      end else begin
         st_q   <= st_d;
         beat_q <= beat_d;
         cnt_q  <= cnt_d;
      end
   end

   assign busy_o        = (st_q != ST_IDLE);
   assign rd_o          = (st_q == ST_RD);
   assign wr_o          = (st_q == ST_WR);
   assign grant_pulse_o = (st_q == ST_END);
   assign cnt_o         = cnt_q;

   // R8: a cycle leaves the wait only when the selected requests were present
   assert_wait_for_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_RD && $past(st_q) == ST_WAIT) |-> $past(ready_i));
   // R6: the live count never rises and steps down by at most one
   assert_count_down_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CW'(1)));
   // R7 / R12: stopping means the count ran out or software stopped the channel
   assert_stop_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> (cnt_q == '0 || $past(abort_i)));
endmodule

// File: rtl/hs_dma_channel.sv
module hs_dma_channel
   import hsdma_pkg::*;
#(
   parameter int AW          = 32,
   parameter int CW          = 24,
   parameter int NUM_LINES   = 15,
   parameter int BURST_BEATS = 4
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 reg_wr_i,
   input  logic [3:0]           reg_addr_i,
   input  logic [31:0]          reg_wdata_i,
   output logic [31:0]          reg_rdata_o,
   output logic                 mem_rd_o,
   output logic                 mem_wr_o,
   output logic                 mem_main_o,
   output logic [1:0]           mem_size_o,
   output logic [AW-1:0]        mem_addr_o,
   output logic [31:0]          mem_wdata_o,
   input  logic [31:0]          mem_rdata_i,
   input  logic [NUM_LINES-1:0] req_i,
   output logic [NUM_LINES-1:0] grant_o,
   output logic                 irq_done_o,
   output logic                 irq_err_o
);
   localparam int RW = 32;

   initial begin
      assert (AW >= 8 && AW <= RW) else $error("AW out of range");
      assert (CW >= 1 && CW <= RW) else $error("CW out of range");
      assert (NUM_LINES >= 1 && NUM_LINES < (1 << LINE_W)) else $error("NUM_LINES out of range");
      assert (BURST_BEATS >= 2) else $error("BURST_BEATS too small");
   end

   logic          busy, eng_rd, eng_wr, grant_pulse, done_evt, err_evt, ready;
   logic [CW-1:0] cnt;
   logic [AW-1:0] src_addr, dst_addr;
   logic [RW-1:0] ctl_q, ctl_view, data_q;
   logic          fin_q, err_q;

   reg_sel_t sel;
   logic     hit, wr_src, wr_dst, wr_cnt, wr_ctl, start, abort, cfg_bad;

   assign sel     = reg_sel_t'(reg_addr_i[3:2]);
   assign hit     = reg_wr_i && (reg_addr_i[1:0] == 2'b00);
   assign wr_src  = hit && sel == SEL_SRC && !busy;
   assign wr_dst  = hit && sel == SEL_DST && !busy;
   assign wr_cnt  = hit && sel == SEL_CNT && !busy;
   assign wr_ctl  = hit && sel == SEL_CTL;
   assign start   = wr_ctl && !busy && reg_wdata_i[CTL_EN];
   assign abort   = wr_ctl && busy && !reg_wdata_i[CTL_EN];
   assign cfg_bad = step_reserved(reg_wdata_i[CTL_SSTEP_LO +: STEP_W])
                  | step_reserved(reg_wdata_i[CTL_DSTEP_LO +: STEP_W])
                  | (reg_wdata_i[CTL_SIZE_LO +: 2] == 2'b11);

   // control fields and status
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctl_q <= '0;
         fin_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (wr_ctl && !busy) ctl_q <= reg_wdata_i;
         fin_q <= done_evt | (fin_q & ~(wr_ctl & ~reg_wdata_i[CTL_FIN]));
         err_q <= err_evt  | (err_q & ~(wr_ctl & ~reg_wdata_i[CTL_ERR]));
      end
   end

   always_comb begin
      ctl_view          = ctl_q;
      ctl_view[CTL_EN]  = busy;
      ctl_view[CTL_FIN] = fin_q;
      ctl_view[CTL_ERR] = err_q;
   end

   always_comb begin
      unique case (sel)
         SEL_SRC: reg_rdata_o = RW'(src_addr);
         SEL_DST: reg_rdata_o = RW'(dst_addr);
         SEL_CNT: reg_rdata_o = RW'(cnt);
         default: reg_rdata_o = ctl_view;
      endcase
   end

   hsdma_addr_step #(.AW(AW)) i_src_step (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (wr_src),
      .ld_val_i (reg_wdata_i[AW-1:0]),
      .adv_i    (eng_rd),
      .code_i   (ctl_q[CTL_SSTEP_LO +: STEP_W]),
      .addr_o   (src_addr)
   );

   hsdma_addr_step #(.AW(AW)) i_dst_step (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ld_i     (wr_dst),
      .ld_val_i (reg_wdata_i[AW-1:0]),
      .adv_i    (eng_wr),
      .code_i   (ctl_q[CTL_DSTEP_LO +: STEP_W]),
      .addr_o   (dst_addr)
   );

   hsdma_pacer #(.NUM_LINES(NUM_LINES)) i_pacer (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .src_line_i    (ctl_q[CTL_SLINE_LO +: LINE_W]),
      .dst_line_i    (ctl_q[CTL_DLINE_LO +: LINE_W]),
      .req_i         (req_i),
      .grant_pulse_i (grant_pulse),
      .ready_o       (ready),
      .grant_o       (grant_o)
   );

   hsdma_engine #(.CW(CW), .BURST_BEATS(BURST_BEATS)) i_engine (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .start_i       (start),
      .cfg_bad_i     (cfg_bad),
      .abort_i       (abort),
      .burst_i       (ctl_q[CTL_BURST]),
      .ready_i       (ready),
      .cnt_wr_i      (wr_cnt),
      .cnt_wdata_i   (reg_wdata_i[CW-1:0]),
      .busy_o        (busy),
      .rd_o          (eng_rd),
      .wr_o          (eng_wr),
      .grant_pulse_o (grant_pulse),
      .done_o        (done_evt),
      .err_o         (err_evt),
      .cnt_o         (cnt)
   );

   // beat data path
   always_ff @(posedge clk_i) begin
      if (!rst_ni)     data_q <= '0;
      else if (eng_rd) data_q <= mem_rdata_i;
   end

   assign mem_rd_o    = eng_rd;
   assign mem_wr_o    = eng_wr;
   assign mem_addr_o  = eng_rd ? src_addr : dst_addr;
   assign mem_main_o  = eng_rd ? ctl_q[CTL_SMAIN] : ctl_q[CTL_DMAIN];
   assign mem_size_o  = ctl_q[CTL_SIZE_LO +: 2];
   assign mem_wdata_o = data_q;
   assign irq_done_o  = fin_q & ctl_q[CTL_FIE];
   assign irq_err_o   = err_q & ctl_q[CTL_EIE];
endmodule

// File: tb/test_hs_dma_channel.sv
module test_hs_dma_channel;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_rd, mem_wr, mem_main;
   logic [1:0]  mem_size;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [NL-1:0] req = '0;
   logic [NL-1:0] grant;
   logic        irq_done, irq_err;

   int n_tests = 0;
   int n_fail  = 0;
   int wr_seen = 0;
   int rd_seen = 0;
   bit finished = 0;

   logic [66:0] exp_q[$];   // {size, bus, addr, data}
   logic [31:0] mm [0:255];
   logic [31:0] pm [0:255];

   always #(CLK_PERIOD/2) clk = ~clk;

   hs_dma_channel i_hs_dma_channel (
      .clk_i(clk), .rst_ni(rst_n),
      .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .mem_main_o(mem_main), .mem_size_o(mem_size),
      .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
      .req_i(req), .grant_o(grant), .irq_done_o(irq_done), .irq_err_o(irq_err)
   );

   function automatic logic [31:0] pat(input logic bus, input logic [31:0] a);
      return (bus ? 32'hA500_0000 : 32'h5A00_0000) | {24'h0, a[7:0]};
   endfunction

   function automatic logic [31:0] mag(input logic [2:0] c);
      case (c[1:0])
         2'd1: return 32'd1;
         2'd2: return 32'd2;
         2'd3: return 32'd4;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] stepped(input logic [31:0] a, input logic [2:0] c, input int k);
      return c[2] ? a - mag(c) * k : a + mag(c) * k;
   endfunction

   function automatic logic [31:0] mk(input logic en, fie, burst, eie, smain, dmain,
                                      input logic [2:0] ss, ds, input logic [3:0] dl,
                                      input logic [1:0] sz, input logic [3:0] sl);
      logic [31:0] c = '0;
      c[0] = en; c[2] = fie; c[3] = burst; c[5] = eie; c[6] = smain; c[7] = dmain;
      c[10:8] = ss; c[14:12] = ds; c[19:16] = dl; c[21:20] = sz; c[27:24] = sl;
      return c;
   endfunction

   // memory and peripheral models
   assign mem_rdata = mem_main ? mm[mem_addr[7:0]] : pm[mem_addr[7:0]];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) begin
            mm[i] <= pat(1'b1, 32'(i));
            pm[i] <= pat(1'b0, 32'(i));
         end
      end else if (mem_wr) begin
         if (mem_main) mm[mem_addr[7:0]] <= mem_wdata;
         else          pm[mem_addr[7:0]] <= mem_wdata;
      end
   end

   // monitor: pops the scoreboard on every write beat
   always @(negedge clk) begin
      if (rst_n && mem_rd) rd_seen++;
      if (rst_n && mem_wr) begin
         wr_seen++;
         n_tests++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R3: unexpected write addr %h data %h, expected none", mem_addr, mem_wdata);
         end else begin
            logic [66:0] e, g;
            e = exp_q.pop_front();
            g = {mem_size, mem_main, mem_addr, mem_wdata};
            if (g !== e) begin
               n_fail++;
               $display("FAIL R3/R4/R5: beat actual %h expected %h", g, e);
            end
         end
      end
   end

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 3000; i++) begin
         rd(4'hC, v);
         if (!v[0]) break;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // driver: pushes expected beats, programs and runs the channel
   task automatic run(input logic smain, dmain, input logic [2:0] ss, ds, input logic [1:0] sz,
                      input logic burst, input int cnt, input logic [31:0] s, d, input logic fie);
      int beats = burst ? 4 : 1;
      for (int k = 0; k < cnt * beats; k++)
         exp_q.push_back({sz, dmain, stepped(d, ds, k), pat(smain, stepped(s, ss, k))});
      wr(4'h0, s);
      wr(4'h4, d);
      wr(4'h8, 32'(cnt));
      wr(4'hC, mk(1'b1, fie, burst, 1'b0, smain, dmain, ss, ds, 4'd0, sz, 4'd0));
      wait_idle();
   endtask

   initial begin
      logic [31:0] v;
      int w0, r0;
      idle(5);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'h0, v); chk("R1 src reset", v, 32'h0);
      rd(4'h4, v); chk("R1 dst reset", v, 32'h0);
      rd(4'h8, v); chk("R1 cnt reset", v, 32'h0);
      rd(4'hC, v); chk("R1 ctl reset", v, 32'h0);
      chk("R7 irq reset", {30'h0, irq_done, irq_err}, 32'h0);
      chk("R8 grant reset", 32'(grant), 32'h0);

      // R1 readback, count width, misaligned write
      wr(4'h0, 32'h1234_5678); wr(4'h4, 32'hCAFE_0004); wr(4'h8, 32'hFFAB_CDEF);
      rd(4'h0, v); chk("R1 src", v, 32'h1234_5678);
      rd(4'h4, v); chk("R1 dst", v, 32'hCAFE_0004);
      rd(4'h8, v); chk("R1 cnt 24 bit", v, 32'h00AB_CDEF);
      wr(4'h1, 32'h0);
      rd(4'h0, v); chk("R1 misaligned ignored", v, 32'h1234_5678);

      // R2 field readback without start
      wr(4'hC, mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b011, 3'b110, 4'd9, 2'b01, 4'd3));
      rd(4'hC, v);
      chk("R2 ctl fields", v, mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'b011, 3'b110, 4'd9, 2'b01, 4'd3));

      // R3 R4 R6 R7: memory to peripheral, +4 source, fixed destination
      w0 = wr_seen;
      run(1'b1, 1'b0, 3'b011, 3'b000, 2'b00, 1'b0, 3, 32'h10, 32'h80, 1'b1);
      rd(4'hC, v);
      chk("R7 finish set, idle", {30'h0, v[1], v[0]}, 32'h2);
      chk("R7 irq_done", 32'(irq_done), 32'h1);
      rd(4'h8, v); chk("R6 count zero at end", v, 32'h0);
      rd(4'h0, v); chk("R4 src final", v, 32'h1C);
      rd(4'h4, v); chk("R4 dst fixed", v, 32'h80);
      chk("R3 beat count", 32'(wr_seen - w0), 32'd3);
      chk("R3 scoreboard drained", 32'(exp_q.size()), 32'd0);

      // R11 clearing
      wr(4'hC, mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b011, 3'b000, 4'd0, 2'b00, 4'd0));
      rd(4'hC, v); chk("R11 finish cleared", 32'(v[1]), 32'h0);
      chk("R11 irq_done low", 32'(irq_done), 32'h0);
      v = mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b011, 3'b000, 4'd0, 2'b00, 4'd0);
      v[1] = 1'b1; v[4] = 1'b1;
      wr(4'hC, v);
      rd(4'hC, v); chk("R11 writing 1 has no effect", {30'h0, v[4], v[1]}, 32'h0);

      // R4 decrement, byte width, peripheral to memory, interrupt disabled
      run(1'b0, 1'b1, 3'b000, 3'b101, 2'b10, 1'b0, 2, 32'h40, 32'hC3, 1'b0);
      rd(4'h4, v); chk("R4 dst decremented", v, 32'hC1);
      rd(4'hC, v); chk("R7 finish without irq enable", 32'(v[1]), 32'h1);
      chk("R7 irq_done gated", 32'(irq_done), 32'h0);
      wr(4'hC, 32'h0);

      // R5 burst: 2 cycles of 4 beats, +2 both sides
      w0 = wr_seen;
      run(1'b1, 1'b0, 3'b010, 3'b010, 2'b01, 1'b1, 2, 32'h20, 32'h90, 1'b0);
      chk("R5 burst beats", 32'(wr_seen - w0), 32'd8);
      rd(4'h0, v); chk("R5 src final", v, 32'h30);
      rd(4'h4, v); chk("R5 dst final", v, 32'hA0);
      wr(4'hC, 32'h0);

      // R8 R6 pacing: source line 5, destination line 3
      for (int k = 0; k < 2; k++)
         exp_q.push_back({2'b00, 1'b0, 32'hA0, pat(1'b1, 32'h30 + 32'(4 * k))});
      wr(4'h0, 32'h30); wr(4'h4, 32'hA0); wr(4'h8, 32'd2);
      w0 = wr_seen;
      wr(4'hC, mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b011, 3'b000, 4'd3, 2'b00, 4'd5));
      idle(10);
      chk("R8 no beat without requests", 32'(wr_seen - w0), 32'd0);
      req[4] = 1'b1;
      idle(10);
      chk("R8 waits for both lines", 32'(wr_seen - w0), 32'd0);
      req[2] = 1'b1;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (grant != '0) break;
      end
      chk("R8 grant lines 5 and 3", 32'(grant), 32'h14);
      req = '0;
      @(negedge clk);
      chk("R8 grant one clock", 32'(grant), 32'h0);
      idle(5);
      rd(4'h8, v); chk("R6 live remaining count", v, 32'd1);
      chk("R8 one cycle done", 32'(wr_seen - w0), 32'd1);
      req[4] = 1'b1; req[2] = 1'b1;
      wait_idle();
      req = '0;
      rd(4'hC, v); chk("R8 paced finish", 32'(v[1]), 32'h1);
      wr(4'hC, 32'h0);

      // R12 R13: stop while waiting, writes ignored while busy
      wr(4'h0, 32'h50); wr(4'h4, 32'hB0); wr(4'h8, 32'd5);
      w0 = wr_seen; r0 = rd_seen;
      wr(4'hC, mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001, 3'b000, 4'd0, 2'b00, 4'd7));
      idle(3);
      wr(4'h0, 32'hFF);
      rd(4'h0, v); chk("R13 src write ignored", v, 32'h50);
      wr(4'h8, 32'd9);
      rd(4'h8, v); chk("R13 cnt write ignored", v, 32'd5);
      wr(4'hC, mk(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b010, 3'b010, 4'd1, 2'b10, 4'd2));
      rd(4'hC, v);
      chk("R12 stopped, R13 fields kept", v,
          mk(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001, 3'b000, 4'd0, 2'b00, 4'd7));
      req[6] = 1'b1;
      idle(10);
      req = '0;
      chk("R12 no access after stop", 32'(wr_seen - w0 + rd_seen - r0), 32'd0);

      // R9 reserved step and width
      r0 = rd_seen;
      wr(4'h8, 32'd4);
      wr(4'hC, mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b100, 3'b000, 4'd0, 2'b00, 4'd0));
      rd(4'hC, v); chk("R9 error set, idle", {30'h0, v[4], v[0]}, 32'h2);
      chk("R9 irq_err", 32'(irq_err), 32'h1);
      idle(5);
      chk("R9 no access", 32'(rd_seen - r0), 32'd0);
      wr(4'hC, mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b001, 3'b000, 4'd0, 2'b00, 4'd0));
      rd(4'hC, v); chk("R11 error cleared", 32'(v[4]), 32'h0);
      chk("R11 irq_err low", 32'(irq_err), 32'h0);
      wr(4'hC, mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'b001, 3'b000, 4'd0, 2'b11, 4'd0));
      rd(4'hC, v); chk("R9 width 11 error", 32'(v[4]), 32'h1);
      idle(5);
      chk("R9 no access for width", 32'(rd_seen - r0), 32'd0);
      wr(4'hC, 32'h0);

      // R10 zero count
      wr(4'h8, 32'd0);
      wr(4'hC, mk(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 3'b001, 3'b001, 4'd0, 2'b00, 4'd0));
      rd(4'hC, v); chk("R10 immediate finish", {30'h0, v[1], v[0]}, 32'h2);
      chk("R10 irq_done", 32'(irq_done), 32'h1);
      idle(5);
      chk("R10 no access", 32'(rd_seen - r0), 32'd0);

      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         finished = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule